// File: doc/BRIEF.md
# Monochrome LCD Line Refresh Controller

This block keeps a bufferless monochrome graphic LCD lit by feeding it from an image held in external memory. The image is packed at one bit per pixel. A line timer fires once per line period. On each firing, the block reads one line's worth of bytes from memory as a back-to-back burst and forwards each byte to the panel's data bus with a shift strobe. It then pulls the line-latch output low for a fixed number of cycles. The latch output is paired with a frame-start output that goes low only while line 0 is latched.

The read pointer starts at a base address and advances by one per byte across line boundaries, so the frame is fetched strictly in sequence. After the last line of a frame, the line counter returns to 0 and the pointer reloads the base address. The default settings are a 320x200 panel (40 bytes per line, 200 lines) and a 100 us line period at 250 MHz. A wider panel needs only a larger bytes-per-line setting.

Memory is read with a fixed one-cycle latency. Data is valid on `mem_rdata` in the cycle after `mem_rd` is high. The panel takes one byte in every cycle in which `lcd_shift` is high.

Top module: `lcd_line_refresh`

## Requirements
- R1: While `rst_n` is low, and directly after its release, `lcd_lp_n` and `lcd_yd_n` are high, while `lcd_shift` and `mem_rd` are low. The first line fetched after reset is line 0, starting at BASE_ADDR.
- R2: Successive falling edges of `lcd_lp_n` are exactly LINE_CYCLES clock cycles apart.
- R3: Each line issues BYTES_PER_LINE read requests in consecutive cycles. The address rises by one on each request.
- R4: The byte returned for a request appears on `lcd_data` with `lcd_shift` high exactly two cycles after that request was made. Bytes leave in request order, with one strobe per byte.
- R5: Exactly BYTES_PER_LINE strobes occur between two latch pulses. After the last strobe, `lcd_lp_n` is low for exactly LP_CYCLES cycles and then returns high.
- R6: `lcd_yd_n` is low only while `lcd_lp_n` is low for line 0. It is high during the latch of every other line.
- R7: After the latch of line LINES-1, the next line is line 0 and its first read address is BASE_ADDR.
- R8: The pointer carries over between lines. The first read address of line n is BASE_ADDR + n*BYTES_PER_LINE.
- R9: A line burst, its drain and its latch pulse all end before the next line tick. No read is issued while `lcd_lp_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | ADDR_W | Frame-buffer read address |
| mem_rd | output | 1 | Read request, one byte per cycle |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| lcd_data | output | DATA_W | Byte presented to the panel |
| lcd_shift | output | 1 | High in each cycle that carries a byte |
| lcd_lp_n | output | 1 | Line latch, active low |
| lcd_yd_n | output | 1 | Frame start, active low, during line 0 latch |

## Verification
The assertions assume the memory answers every request with exactly one cycle of latency. They also assume LINE_CYCLES leaves room for the burst, the two-cycle drain and the latch pulse. Without that margin, a tick would land while the engine is busy. The bench memory model registers `pattern(address)` on the clock edge that ends a request cycle, so it always meets that latency. The bench also chooses a short line period that still exceeds BYTES_PER_LINE+LP_CYCLES+3. The only other input is reset, which is applied only on a falling clock edge.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

  // Phases of one line transfer
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_DRAIN = 2'd2,
    PH_LATCH = 2'd3
  } phase_t;

  // Cycles between last read request and last strobe
  localparam int unsigned DRAIN_CYCLES = 2;

endpackage

// File: rtl/lcdr_line_timer.sv
module lcdr_line_timer #(
  parameter int unsigned LINE_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned TW = (LINE_CYCLES > 1) ? $clog2(LINE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(LINE_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/lcdr_burst_ctrl.sv
module lcdr_burst_ctrl
  import lcdr_pkg::*;
#(
  parameter int unsigned BYTES_PER_LINE = 40,
  parameter int unsigned LP_CYCLES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic rd_en,
  output logic line_done,
  output logic latch_n
);

  localparam int unsigned CMAX = (BYTES_PER_LINE > LP_CYCLES) ? BYTES_PER_LINE : LP_CYCLES;
  localparam int unsigned CW   = $clog2(CMAX + DRAIN_CYCLES + 1);
  localparam logic [CW-1:0] FETCH_LAST = CW'(BYTES_PER_LINE - 1);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_CYCLES - 1);
  localparam logic [CW-1:0] LATCH_LAST = CW'(LP_CYCLES - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_last;

  always_comb begin
    unique case (ph_q)
      PH_FETCH: cnt_last = (cnt_q == FETCH_LAST);
      PH_DRAIN: cnt_last = (cnt_q == DRAIN_LAST);
      PH_LATCH: cnt_last = (cnt_q == LATCH_LAST);
      default:  cnt_last = 1'b0;
    endcase
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (tick) begin
          ph_d  = PH_FETCH;
          cnt_d = '0;
        end
      end
      PH_FETCH: begin
        if (cnt_last) begin
          ph_d  = PH_DRAIN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DRAIN: begin
        if (cnt_last) begin
          ph_d  = PH_LATCH;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_LATCH: begin
        if (cnt_last) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign rd_en     = (ph_q == PH_FETCH);
  assign latch_n   = (ph_q != PH_LATCH);
  assign line_done = (ph_q == PH_LATCH) && cnt_last;

  // R9
  tick_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (ph_q == PH_IDLE));

  // R5
  latch_follows_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_n) |-> ($past(ph_q) == PH_DRAIN));

endmodule

// File: rtl/lcdr_addr_gen.sv
module lcdr_addr_gen #(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned BASE_ADDR      = 0,
  parameter int unsigned BYTES_PER_LINE = 40,
  parameter int unsigned LINES          = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              line_done,
  output logic [ADDR_W-1:0] addr,
  output logic              first_line
);

  localparam int unsigned LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [LW-1:0]     LINE_LAST = LW'(LINES - 1);
  localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [LW-1:0]     line_q, line_d;
  logic              wrap;

  assign wrap = line_done && (line_q == LINE_LAST);

  always_comb begin
    ptr_d  = ptr_q;
    line_d = line_q;
    if (rd_en) begin
      ptr_d = ptr_q + 1'b1;
    end
    if (line_done) begin
      if (wrap) begin
        line_d = '0;
        ptr_d  = BASE;
      end else begin
        line_d = line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= BASE;
      line_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      line_q <= line_d;
    end
  end

  assign addr       = ptr_q;
  assign first_line = (line_q == '0);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R7
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ((ptr_q == BASE) && (line_q == '0)));

  // R8
  ptr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !wrap) |=> (ptr_q == $past(ptr_q)));

  // R7
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LINE_LAST);

endmodule

// File: rtl/lcdr_byte_pipe.sv
module lcdr_byte_pipe #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] out_data,
  output logic              out_strobe
);

  logic              rd_d1_q;
  logic              stb_q;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (rd_d1_q) data_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d1_q <= 1'b0;
      stb_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      rd_d1_q <= rd_en;
      stb_q   <= rd_d1_q;
      data_q  <= data_d;
    end
  end

  assign out_data   = data_q;
  assign out_strobe = stb_q;

  // R4
  shift_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en, 2) |-> out_strobe);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_d1_q) |-> $stable(out_data));

endmodule

// File: rtl/lcd_line_refresh.sv
module lcd_line_refresh #(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned BASE_ADDR      = 16'h1000,
  parameter int unsigned BYTES_PER_LINE = 40,
  parameter int unsigned LINES          = 200,
  parameter int unsigned LINE_CYCLES    = 25000,
  parameter int unsigned LP_CYCLES      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] lcd_data,
  output logic              lcd_shift,
  output logic              lcd_lp_n,
  output logic              lcd_yd_n
);

  logic tick;
  logic rd_en;
  logic line_done;
  logic latch_n;
  logic first_line;

  lcdr_line_timer #(
    .LINE_CYCLES (LINE_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  lcdr_burst_ctrl #(
    .BYTES_PER_LINE (BYTES_PER_LINE),
    .LP_CYCLES      (LP_CYCLES)
  ) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rd_en     (rd_en),
    .line_done (line_done),
    .latch_n   (latch_n)
  );

  lcdr_addr_gen #(
    .ADDR_W         (ADDR_W),
    .BASE_ADDR      (BASE_ADDR),
    .BYTES_PER_LINE (BYTES_PER_LINE),
    .LINES          (LINES)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .line_done  (line_done),
    .addr       (mem_addr),
    .first_line (first_line)
  );

  lcdr_byte_pipe #(
    .DATA_W (DATA_W)
  ) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rdata      (mem_rdata),
    .out_data   (lcd_data),
    .out_strobe (lcd_shift)
  );

  assign mem_rd   = rd_en;
  assign lcd_lp_n = latch_n;
  assign lcd_yd_n = latch_n | ~first_line;

  // R6
  yd_inside_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_yd_n |-> !lcd_lp_n);

  // R9
  no_read_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_lp_n |-> !mem_rd);

  // R5
  no_shift_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_lp_n |-> !lcd_shift);

endmodule

// File: tb/sim_lcd_line_refresh.sv
`timescale 1ns/1ps
module sim_lcd_line_refresh;

  localparam int AW    = 16;
  localparam int DW    = 8;
  localparam int BASE  = 16'h1000;
  localparam int BPL   = 40;
  localparam int NL    = 200;
  localparam int LCYC  = 80;
  localparam int LPW   = 2;
  localparam int TOP   = BASE + BPL * NL;

  // Checkpoint table: line index, expected frame-start low at its latch
  localparam int TBL_N = 8;
  localparam int TBL_LINE [TBL_N] = '{0, 1, 2, 37, 99, 150, 198, 199};
  localparam bit TBL_YD   [TBL_N] = '{1, 0, 0, 0, 0, 0, 0, 0};

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] lcd_data;
  logic          lcd_shift;
  logic          lcd_lp_n;
  logic          lcd_yd_n;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  lcd_line_refresh #(
    .ADDR_W (AW), .DATA_W (DW), .BASE_ADDR (BASE), .BYTES_PER_LINE (BPL),
    .LINES (NL), .LINE_CYCLES (LCYC), .LP_CYCLES (LPW)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .mem_addr (mem_addr), .mem_rd (mem_rd),
    .mem_rdata (mem_rdata), .lcd_data (lcd_data), .lcd_shift (lcd_shift),
    .lcd_lp_n (lcd_lp_n), .lcd_yd_n (lcd_yd_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input int a);
    logic [15:0] v;
    v = 16'(a);
    return v[7:0] ^ v[15:8] ^ 8'h5A;
  endfunction

  function automatic int nxt(input int a);
    return (a + 1 == TOP) ? BASE : a + 1;
  endfunction

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= pat(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Monitor state
  int exp_rd, exp_out, exp_line, bytes, lp_low, last_fall, lines_done;
  bit rd_h1, rd_h2, rd_prev, lp_prev;
  bit yd_seen [NL];
  int first_addr [NL];

  always @(negedge clk) begin
    if (!rst_n) begin
      exp_rd = BASE; exp_out = BASE; exp_line = 0; bytes = 0; lp_low = 0;
      last_fall = -1; rd_h1 = 0; rd_h2 = 0; rd_prev = 0; lp_prev = 1;
      yd_seen[0] = 0; first_addr[0] = -1;
    end else begin
      if (mem_rd) begin
        if (!rd_prev) begin
          first_addr[exp_line] = int'(mem_addr);
          if (exp_line == 0 && lines_done > 0)
            chk(int'(mem_addr) == BASE, "R7", int'(mem_addr), BASE);
          else
            chk(int'(mem_addr) == BASE + exp_line * BPL, "R8", int'(mem_addr), BASE + exp_line * BPL);
        end
        chk(int'(mem_addr) == exp_rd, "R3", int'(mem_addr), exp_rd);
        chk(lcd_lp_n, "R9", 0, 1);
        exp_rd = nxt(exp_rd);
      end
      if (lcd_shift) begin
        chk(rd_h2, "R4", 0, 1);
        chk(lcd_data == pat(exp_out), "R4", int'(lcd_data), int'(pat(exp_out)));
        exp_out = nxt(exp_out);
        bytes++;
      end
      if (!lcd_yd_n)
        chk(!lcd_lp_n && exp_line == 0, "R6", exp_line, 0);
      if (!lcd_lp_n && lp_prev) begin
        chk(bytes == BPL, "R5", bytes, BPL);
        yd_seen[exp_line] = !lcd_yd_n;
        if (last_fall >= 0) chk(cyc - last_fall == LCYC, "R2", cyc - last_fall, LCYC);
        last_fall = cyc;
        lp_low = 1;
        bytes = 0;
      end else if (!lcd_lp_n) begin
        lp_low++;
      end
      if (lcd_lp_n && !lp_prev) begin
        chk(lp_low == LPW, "R5", lp_low, LPW);
        exp_line = (exp_line + 1) % NL;
        lines_done++;
      end
      rd_h2 = rd_h1; rd_h1 = mem_rd; rd_prev = mem_rd; lp_prev = lcd_lp_n;
    end
  end

  task automatic reset_outputs_chk();
    chk(lcd_lp_n == 1'b1, "R1", int'(lcd_lp_n), 1);
    chk(lcd_yd_n == 1'b1, "R1", int'(lcd_yd_n), 1);
    chk(lcd_shift == 1'b0, "R1", int'(lcd_shift), 0);
    chk(mem_rd == 1'b0, "R1", int'(mem_rd), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 0; lines_done = 0;
    mem_rdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    reset_outputs_chk();
    rst_n = 1'b1;
    @(negedge clk);
    reset_outputs_chk();

    // Run one full frame plus a few lines past the wrap (R7)
    while (lines_done < NL + 3) @(negedge clk);

    // Table walk: per-line latch and start address
    for (int i = 0; i < TBL_N; i++) begin
      chk(yd_seen[TBL_LINE[i]] == TBL_YD[i], "R6", int'(yd_seen[TBL_LINE[i]]), int'(TBL_YD[i]));
      chk(first_addr[TBL_LINE[i]] == BASE + TBL_LINE[i] * BPL, "R8",
          first_addr[TBL_LINE[i]], BASE + TBL_LINE[i] * BPL);
    end

    // Directed: reset in the middle of a burst (R1)
    while (!mem_rd) @(negedge clk);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    reset_outputs_chk();
    begin
      int base_lines;
      base_lines = lines_done;
      rst_n = 1'b1;
      while (lines_done == base_lines) @(negedge clk);
    end
    chk(yd_seen[0] == 1'b1, "R1", int'(yd_seen[0]), 1);
    chk(first_addr[0] == BASE, "R1", first_addr[0], BASE);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule